// File: doc/BRIEF.md
# Victim Line Buffer

This block is a small, fully associative store of cache lines placed beside a direct-mapped cache. Every line the direct-mapped cache throws out is written into it. When the direct-mapped cache misses, the requested line address is probed here first. On a hit the line is handed back to the main cache and the line it displaces takes over the same slot. Only on a probe miss is a request raised toward the next memory level.

The buffer adds associativity to the few sets of the main cache that conflict most. Capacity is set by a parameter, normally 4 or 8 entries, and line and address widths are parameters too. New evictions go into slots in circular allocation order. Once the buffer is full, the entry written earliest is the one overwritten. A flush input empties the buffer in one cycle.

Top module: `victim_store`

## Requirements
- R1: After reset no entry is valid, `resp_valid_o` and `fwd_req_o` are 0 and `lookup_ready_o` is 1.
- R2: An eviction that is not part of a probe hit writes its line into the slot at the allocation pointer, and the pointer then advances by one and wraps to 0 after the last slot. With the buffer full, each new eviction therefore overwrites the line written earliest (first in, first out).
- R3: A probe is accepted in a cycle where `lookup_valid_i` and `lookup_ready_o` are both 1. Exactly one cycle later `resp_valid_o` is 1 for one cycle. In no other cycle is `resp_valid_o` 1.
- R4: A probe hits only when a valid entry holds the full `ADDR_W`-bit line address that was probed. All entries are compared at once.
- R5: On a probe hit, `resp_hit_o` is 1 and `resp_data_o` carries the stored line. If an eviction is offered in the same cycle, that displaced line takes the hit entry's slot (swap). Otherwise the hit entry becomes invalid. In both cases the allocation pointer does not move.
- R6: On a probe miss, `resp_hit_o` is 0 and `resp_data_o` is 0. In the next cycle `fwd_req_o` is 1 and `fwd_addr_o` equals the probed address. An eviction offered in the same cycle is written as in R2.
- R7: `fwd_req_o` and `fwd_addr_o` hold steady until a clock edge at which `fwd_ack_i` is 1, and `fwd_req_o` is 0 from the next cycle. While `fwd_req_o` is 1, `lookup_ready_o` is 0. A probe offered then gets no response and leaves the buffer unchanged. A probe hit never raises `fwd_req_o`.
- R8: `flush_i` clears every valid bit in one cycle. A probe in the same cycle sees an empty buffer and misses. An eviction in the same cycle is written and is valid afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Invalidate all entries |
| evict_valid_i | input | 1 | A line is being discarded by the main cache |
| evict_addr_i | input | ADDR_W | Line address of the discarded line |
| evict_data_i | input | LINE_W | Contents of the discarded line |
| lookup_valid_i | input | 1 | Probe request after a main-cache miss |
| lookup_addr_i | input | ADDR_W | Line address being probed |
| lookup_ready_o | output | 1 | Probe can be accepted this cycle |
| resp_valid_o | output | 1 | Probe result is present |
| resp_hit_o | output | 1 | Probe found the line |
| resp_data_o | output | LINE_W | Line returned to the main cache on a hit, 0 on a miss |
| fwd_req_o | output | 1 | Request to the next level is pending |
| fwd_addr_o | output | ADDR_W | Line address requested from the next level |
| fwd_ack_i | input | 1 | Next level accepts the pending request |

## Verification
The first pattern is a run of evictions that goes past capacity, followed by probes of the first and second lines written. This separates first-in-first-out replacement from any other victim choice. Probe hits are tried both with and without a displaced line, which tells a true swap from a plain invalidation. Misses are tried with delayed acknowledges to show that the request holds steady, and probes offered while busy must leave an entry that they would otherwise have removed. A flush that coincides with a probe and with an eviction pins down the order of clear, compare and write. A long mixed random run is then compared cycle by cycle with a behavioural model.

// File: rtl/victim_pkg.sv
package victim_pkg;

    // kind of work done in one cycle, from {probe accepted, eviction offered}
    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_EVICT = 2'b01,
        OP_PROBE = 2'b10,
        OP_SWAP  = 2'b11
    } op_e;

endpackage

// File: rtl/victim_match.sv
module victim_match #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 26,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0]             valid_i,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] tag_i,
    input  logic [ADDR_W-1:0]              key_i,
    output logic                           hit_o,
    output logic [IDX_W-1:0]               idx_o
);

    logic [ENTRIES-1:0] match;

    // one comparator per entry, all working in parallel
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid_i[g] && (tag_i[g] == key_i);
    end

    always_comb begin
        idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) idx_o = IDX_W'(i);
        end
    end

    assign hit_o = |match;

endmodule

// File: rtl/victim_fwd.sv
module victim_fwd #(
    parameter int ADDR_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ack_i,
    output logic              req_o,
    output logic [ADDR_W-1:0] addr_o
);

    typedef struct packed {
        logic              req;
        logic [ADDR_W-1:0] addr;
    } fwd_t;

    fwd_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (f_q.req && ack_i) f_d.req = 1'b0;
        if (start_i) begin
            f_d.req  = 1'b1;
            f_d.addr = addr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign req_o  = f_q.req;
    assign addr_o = f_q.addr;

    // R7
    fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.req && !ack_i |=> f_q.req && $stable(f_q.addr));

    // R7
    fwd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.req && ack_i && !start_i |=> !f_q.req);

endmodule

// File: rtl/victim_store.sv
module victim_store #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 26,
    parameter int LINE_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              evict_valid_i,
    input  logic [ADDR_W-1:0] evict_addr_i,
    input  logic [LINE_W-1:0] evict_data_i,
    input  logic              lookup_valid_i,
    input  logic [ADDR_W-1:0] lookup_addr_i,
    output logic              lookup_ready_o,
    output logic              resp_valid_o,
    output logic              resp_hit_o,
    output logic [LINE_W-1:0] resp_data_o,
    output logic              fwd_req_o,
    output logic [ADDR_W-1:0] fwd_addr_o,
    input  logic              fwd_ack_i
);
    import victim_pkg::*;

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][ADDR_W-1:0] tag;
        logic [ENTRIES-1:0][LINE_W-1:0] data;
        logic [IDX_W-1:0]               ptr;
        logic                           rvalid;
        logic                           rhit;
        logic [LINE_W-1:0]              rdata;
    } store_t;

    store_t s_d, s_q;

    logic [ENTRIES-1:0] live;
    logic               probe_hit;
    logic [IDX_W-1:0]   hit_idx;
    logic               accept;
    op_e                op;

    // a flush in this cycle hides every entry from the compare
    assign live   = flush_i ? '0 : s_q.valid;
    assign accept = lookup_valid_i && lookup_ready_o;
    assign op     = op_e'({accept, evict_valid_i});

    victim_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_match (
        .valid_i (live),
        .tag_i   (s_q.tag),
        .key_i   (lookup_addr_i),
        .hit_o   (probe_hit),
        .idx_o   (hit_idx)
    );

    victim_fwd #(.ADDR_W(ADDR_W)) u_fwd (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (accept && !probe_hit),
        .addr_i  (lookup_addr_i),
        .ack_i   (fwd_ack_i),
        .req_o   (fwd_req_o),
        .addr_o  (fwd_addr_o)
    );

    always_comb begin
        s_d        = s_q;
        s_d.valid  = live;
        s_d.rvalid = accept;
        s_d.rhit   = accept && probe_hit;
        s_d.rdata  = '0;
        unique case (op)
            OP_PROBE, OP_SWAP: begin
                if (probe_hit) begin
                    s_d.rdata = s_q.data[hit_idx];
                    if (op == OP_SWAP) begin
                        s_d.tag[hit_idx]  = evict_addr_i;
                        s_d.data[hit_idx] = evict_data_i;
                    end else begin
                        s_d.valid[hit_idx] = 1'b0;
                    end
                end else if (op == OP_SWAP) begin
                    s_d.valid[s_q.ptr] = 1'b1;
                    s_d.tag[s_q.ptr]   = evict_addr_i;
                    s_d.data[s_q.ptr]  = evict_data_i;
                    s_d.ptr = (s_q.ptr == LAST) ? '0 : s_q.ptr + 1'b1;
                end
            end
            OP_EVICT: begin
                s_d.valid[s_q.ptr] = 1'b1;
                s_d.tag[s_q.ptr]   = evict_addr_i;
                s_d.data[s_q.ptr]  = evict_data_i;
                s_d.ptr = (s_q.ptr == LAST) ? '0 : s_q.ptr + 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lookup_ready_o = !fwd_req_o;
    assign resp_valid_o   = s_q.rvalid;
    assign resp_hit_o     = s_q.rhit;
    assign resp_data_o    = s_q.rdata;

    // R3
    resp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> resp_valid_o);

    // R3
    resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !resp_valid_o);

    // R6
    fwd_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !probe_hit |=> fwd_req_o && fwd_addr_o == $past(lookup_addr_i));

    // R7
    no_fwd_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid_o && resp_hit_o |-> !fwd_req_o);

    // R5
    swap_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && probe_hit && evict_valid_i |=>
            s_q.valid[$past(hit_idx)] && s_q.tag[$past(hit_idx)] == $past(evict_addr_i));

    // R5
    hit_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && probe_hit |=> $stable(s_q.ptr));

    // R8
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i && !evict_valid_i |=> s_q.valid == '0);

endmodule

// File: tb/victim_store_bench.sv
module victim_store_bench;

    localparam int E  = 4;
    localparam int AW = 26;
    localparam int LW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush_i = 1'b0;
    logic          evict_valid_i = 1'b0;
    logic [AW-1:0] evict_addr_i = '0;
    logic [LW-1:0] evict_data_i = '0;
    logic          lookup_valid_i = 1'b0;
    logic [AW-1:0] lookup_addr_i = '0;
    logic          lookup_ready_o;
    logic          resp_valid_o;
    logic          resp_hit_o;
    logic [LW-1:0] resp_data_o;
    logic          fwd_req_o;
    logic [AW-1:0] fwd_addr_o;
    logic          fwd_ack_i = 1'b0;

    always #2.5 clk = ~clk;

    victim_store #(.ENTRIES(E), .ADDR_W(AW), .LINE_W(LW)) u_victim_store (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
        .evict_valid_i(evict_valid_i), .evict_addr_i(evict_addr_i), .evict_data_i(evict_data_i),
        .lookup_valid_i(lookup_valid_i), .lookup_addr_i(lookup_addr_i),
        .lookup_ready_o(lookup_ready_o), .resp_valid_o(resp_valid_o),
        .resp_hit_o(resp_hit_o), .resp_data_o(resp_data_o),
        .fwd_req_o(fwd_req_o), .fwd_addr_o(fwd_addr_o), .fwd_ack_i(fwd_ack_i)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    int unsigned nxt = 1;

    // behavioural reference state
    bit          m_v [E];
    logic [AW-1:0] m_t [E];
    logic [LW-1:0] m_d [E];
    int          m_ptr = 0;
    bit          m_req = 0;
    logic [AW-1:0] m_fa = '0;
    bit          e_rv = 0, e_rh = 0;
    logic [LW-1:0] e_rd = '0;

    task automatic check(input bit ok, input string tag, input logic [LW-1:0] act,
                         input logic [LW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        check(resp_valid_o == e_rv, "R3 resp_valid", LW'(resp_valid_o), LW'(e_rv));
        check(resp_hit_o == e_rh, "R4 resp_hit", LW'(resp_hit_o), LW'(e_rh));
        check(resp_data_o == e_rd, "R5 resp_data", resp_data_o, e_rd);
        check(fwd_req_o == m_req, "R7 fwd_req", LW'(fwd_req_o), LW'(m_req));
        if (m_req) check(fwd_addr_o == m_fa, "R6 fwd_addr", LW'(fwd_addr_o), LW'(m_fa));
        check(lookup_ready_o == !m_req, "R7 ready", LW'(lookup_ready_o), LW'(!m_req));
    endtask

    function automatic logic [LW-1:0] line_of(input logic [AW-1:0] a);
        return {6'h2a, a, ~a[AW-1:AW-6], a};
    endfunction

    // drive one cycle, advance the model, compare at the next falling edge
    task automatic cycle(input bit fl, input bit ev, input logic [AW-1:0] ea,
                         input bit lv, input logic [AW-1:0] la, input bit ack);
        bit acc, hit;
        int hi;
        flush_i = fl; evict_valid_i = ev; evict_addr_i = ea; evict_data_i = line_of(ea);
        lookup_valid_i = lv; lookup_addr_i = la; fwd_ack_i = ack;
        acc = lv && !m_req;
        if (fl) for (int i = 0; i < E; i++) m_v[i] = 0;
        hit = 0; hi = 0;
        if (acc) for (int i = 0; i < E; i++)
            if (!hit && m_v[i] && m_t[i] == la) begin hit = 1; hi = i; end
        if (m_req && ack) m_req = 0;
        if (acc && !hit) begin m_req = 1; m_fa = la; end
        e_rv = acc; e_rh = acc && hit; e_rd = (acc && hit) ? m_d[hi] : '0;
        if (acc && hit) begin
            if (ev) begin m_t[hi] = ea; m_d[hi] = line_of(ea); end
            else m_v[hi] = 0;
        end else if (ev) begin
            m_v[m_ptr] = 1; m_t[m_ptr] = ea; m_d[m_ptr] = line_of(ea);
            m_ptr = (m_ptr + 1) % E;
        end
        @(negedge clk);
        compare_all();
    endtask

    function automatic logic [AW-1:0] fresh();
        nxt++;
        return AW'(nxt);
    endfunction

    task automatic idle(input bit ack);
        cycle(0, 0, '0, 0, '0, ack);
    endtask

    initial begin
        logic [AW-1:0] a [6];
        logic [AW-1:0] x;
        for (int i = 0; i < E; i++) m_v[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!resp_valid_o && !fwd_req_o && lookup_ready_o, "R1 reset outputs",
              LW'({resp_valid_o, fwd_req_o, lookup_ready_o}), LW'(3'b001));

        // R2 fill past capacity, oldest must be gone
        for (int i = 0; i < 6; i++) a[i] = fresh();
        for (int i = 0; i < 5; i++) cycle(0, 1, a[i], 0, '0, 0);
        cycle(0, 0, '0, 1, a[0], 0);
        check(resp_hit_o == 0, "R2 oldest replaced", LW'(resp_hit_o), 0);
        cycle(0, 0, '0, 0, '0, 1);
        cycle(0, 0, '0, 1, a[1], 0);
        check(resp_hit_o == 1 && resp_data_o == line_of(a[1]), "R2 second oldest kept",
              resp_data_o, line_of(a[1]));

        // R5 plain hit invalidates: a[1] now gone
        cycle(0, 0, '0, 1, a[1], 0);
        check(resp_hit_o == 0, "R5 hit entry invalidated", LW'(resp_hit_o), 0);
        cycle(0, 0, '0, 0, '0, 1);

        // R5 swap: hit a[2] while displacing x, then x must hit
        x = fresh();
        cycle(0, 1, x, 1, a[2], 0);
        check(resp_hit_o == 1 && resp_data_o == line_of(a[2]), "R5 swap returns line",
              resp_data_o, line_of(a[2]));
        cycle(0, 0, '0, 1, x, 0);
        check(resp_hit_o == 1 && resp_data_o == line_of(x), "R5 displaced line in slot",
              resp_data_o, line_of(x));

        // R4 address differing in one bit misses
        cycle(0, 0, '0, 1, a[3] ^ AW'(1 << (AW - 1)), 0);
        check(resp_hit_o == 0, "R4 upper bit differs", LW'(resp_hit_o), 0);

        // R7 request held, busy probe of a[3] ignored
        for (int k = 0; k < 3; k++) begin
            cycle(0, 0, '0, 1, a[3], 0);
            check(resp_valid_o == 0 && fwd_req_o == 1, "R7 busy probe ignored",
                  LW'({resp_valid_o, fwd_req_o}), LW'(2'b01));
        end
        cycle(0, 0, '0, 0, '0, 1);
        check(fwd_req_o == 0, "R7 drop after ack", LW'(fwd_req_o), 0);
        cycle(0, 0, '0, 1, a[3], 0);
        check(resp_hit_o == 1, "R7 entry survived busy probe", LW'(resp_hit_o), 1);

        // R8 flush with probe and eviction in the same cycle
        x = fresh();
        cycle(1, 1, x, 1, a[4], 0);
        check(resp_valid_o == 1 && resp_hit_o == 0, "R8 probe during flush misses",
              LW'(resp_hit_o), 0);
        cycle(0, 0, '0, 0, '0, 1);
        cycle(0, 0, '0, 1, a[4], 0);
        check(resp_hit_o == 0, "R8 old entry cleared", LW'(resp_hit_o), 0);
        cycle(0, 0, '0, 0, '0, 1);
        cycle(0, 0, '0, 1, x, 0);
        check(resp_hit_o == 1, "R8 coincident eviction kept", LW'(resp_hit_o), 1);

        // mixed random traffic against the model (R2-R8)
        for (int c = 0; c < 3000; c++) begin
            bit ev, lv, fl, ack;
            logic [AW-1:0] la;
            int pick;
            ev  = ($urandom % 3) != 0;
            lv  = ($urandom % 2) != 0;
            fl  = ($urandom % 97) == 0;
            ack = ($urandom % 3) == 0;
            pick = $urandom % E;
            la = (m_v[pick] && ($urandom % 2)) ? m_t[pick] : AW'(1 + ($urandom % nxt));
            cycle(fl, ev, ev ? fresh() : '0, lv, la, ack);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule